// File: doc/BRIEF.md
# MII PHY Scan and Setup Sequencer

This block walks the management bus once per start request, looking for attached Ethernet PHYs and bringing each one it keeps into a known configuration. It drives a separate MDIO master through a simple request/acknowledge handshake: it presents a PHY address, a register number, a read/write flag and write data, holds them until the master acknowledges, and takes read data on that acknowledge. The serial framing itself lives in the master and is not part of this block.

Each address is probed by reading its status register. A PHY whose status looks valid is kept in a small table until the table is full. For every kept PHY the block reads the control and advertisement registers. If no ability is advertised, it builds an advertisement from the status capabilities. It picks the advertisement to use from a priority chain and writes it only when needed. It then forms a new control value that either turns auto-negotiation on or forces speed and duplex, and writes it only when the value changes. When auto-negotiation is switched on or off, the control register is written twice with a settling pause in between, because some PHYs only take forced settings after the enable change.

The FSM states are IDLE, PROBE, RD_CTRL, RD_ADV, RD_CAP, PICK, WR_ADV, WR_CTRL1, SETTLE, WR_CTRL2, NEXT, FILL and DONE. The transitions are:
- IDLE or DONE go to PROBE on start.
- PROBE goes to RD_CTRL when the status is accepted, otherwise to NEXT.
- RD_CTRL goes to RD_ADV.
- RD_ADV goes to RD_CAP when no ability bit is set, otherwise to PICK.
- RD_CAP goes to PICK.
- PICK goes to WR_ADV when the advertisement must change. Otherwise it takes the control route.
- WR_ADV takes the control route.
- The control route goes to WR_CTRL1 if the value changes and the enable bit flips, to WR_CTRL2 if the value changes only, and to NEXT if nothing changes.
- WR_CTRL1 goes to SETTLE, SETTLE goes to WR_CTRL2 when the timer expires, and WR_CTRL2 goes to NEXT.
- NEXT goes to FILL after the last address or once the table is full, otherwise back to PROBE.
- FILL goes to DONE.

Top module: `mii_scan_seq`

## Requirements
- R1: After start, status register 1 is read at PHY addresses 1, 2, ... 31 and then 0, in that order. Probing stops after the address at which the table (SLOTS entries) became full.
- R2: A PHY is kept when (status & 0x8301) == 0x8001, or when status bit 9 is 0 and any of status bits 14..11 is 1. Any other PHY is skipped with no further access, and an absent PHY returns 0xFFFF.
- R3: For a kept PHY, register 0 and then register 4 are read. If bits 8..5 of the register 4 value are all 0, status register 1 is read again and the advertisement is taken as ((status >> 6) & 0x03E0) | 1.
- R4: The advertisement chosen follows this priority. First comes the global value, which is loaded from cfg_adv at start, when it is nonzero. Next comes the slot's stored value when nonzero. Last comes the PHY's value, which then becomes both the global value and the slot's value. A global value that is used is also stored in the slot. Slot values are cleared only by reset.
- R5: Register 4 is written with the chosen advertisement only when it differs from the value read or derived.
- R6: With force_media = 0, control bit 12 (0x1000) is set; if that changes the value, bit 9 (0x0200) is also set and the enable flip is noted. With force_media = 1, bit 12 is cleared and a change counts as a flip.
- R7: Control bits 15, 14, 13, 11, 10, 8 and 7 (mask 0xED80) are then cleared. Bit 8 is set when full_duplex = 1, and bit 13 is set when force_media = 1 and media_100 = 1.
- R8: Register 0 is written only when the new value differs from the value read. After an enable flip, it is written twice with at least SETTLE_CYCLES clocks between the first acknowledge and the second request.
- R9: When mii_expected = 1 and no PHY is kept, slot 0 of the table holds address 1 and phy_count stays 0.
- R10: phy_table slot k (bits 5k+4..5k) holds the k-th kept address, and phy_count is the number of kept PHYs. Start clears the table and count. done is 1 only in DONE, which holds until the next start. After reset, done, phy_count, phy_table and mdio_req are 0.
- R11: Once mdio_req is raised, mdio_wr, mdio_phy, mdio_reg and mdio_wdata stay steady until the cycle in which mdio_ack is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a scan when idle or done |
| mii_expected | input | 1 | A PHY should be present; selects the address-1 fallback |
| force_media | input | 1 | 1 forces speed/duplex, 0 selects auto-negotiation |
| media_100 | input | 1 | The forced medium is 100 Mb/s |
| full_duplex | input | 1 | Request full duplex in the control value |
| cfg_adv | input | 16 | Configured global advertisement, 0 when unset |
| mdio_req | output | 1 | Management transaction request |
| mdio_wr | output | 1 | 1 write, 0 read |
| mdio_phy | output | 5 | PHY address of the transaction |
| mdio_reg | output | 5 | Register number of the transaction |
| mdio_wdata | output | 16 | Write data |
| mdio_ack | input | 1 | One-cycle completion from the MDIO master |
| mdio_rdata | input | 16 | Read data, valid with mdio_ack |
| phy_table | output | SLOTS*5 | Kept PHY addresses, slot 0 in the low bits |
| phy_count | output | clog2(SLOTS+1) | Number of kept PHYs |
| done | output | 1 | Scan finished |

## Verification
The hardest case to reach is the slot-value branch of the advertisement priority. It only matters when the global value is zero and a slot already holds something from an earlier scan, and only reset clears the slot. The stimulus gets there in three steps. A reset is followed by a scan with cfg_adv = 0, so the first PHY's own advertisement becomes both the global and the slot value, and the second PHY is then forced to it. A second scan without reset follows, after the bench has changed that PHY's advertisement behind the block's back, so only the stored slot value can explain the write that follows. The double control write is reached with both auto and forced media, and the bench measures the pause between the two writes.

// File: rtl/mii_scan_pkg.sv
package mii_scan_pkg;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;

    localparam logic [ADDR_W-1:0] REG_CTRL = 5'd0;
    localparam logic [ADDR_W-1:0] REG_STAT = 5'd1;
    localparam logic [ADDR_W-1:0] REG_ADV  = 5'd4;

    // control register bits
    localparam logic [DATA_W-1:0] CTRL_AN_EN    = 16'h1000;
    localparam logic [DATA_W-1:0] CTRL_AN_RESTART = 16'h0200;
    localparam logic [DATA_W-1:0] CTRL_FDX      = 16'h0100;
    localparam logic [DATA_W-1:0] CTRL_SPD100   = 16'h2000;
    localparam logic [DATA_W-1:0] CTRL_SCRUB    = 16'hED80;

    // status / advertisement patterns
    localparam logic [DATA_W-1:0] STAT_PAT_MASK = 16'h8301;
    localparam logic [DATA_W-1:0] STAT_PAT_VAL  = 16'h8001;
    localparam logic [DATA_W-1:0] STAT_ABIL     = 16'h7800;
    localparam logic [DATA_W-1:0] ADV_ABIL      = 16'h01E0;
    localparam logic [DATA_W-1:0] CAP_MASK      = 16'h03E0;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PROBE,
        S_RD_CTRL,
        S_RD_ADV,
        S_RD_CAP,
        S_PICK,
        S_WR_ADV,
        S_WR_CTRL1,
        S_SETTLE,
        S_WR_CTRL2,
        S_NEXT,
        S_FILL,
        S_DONE
    } scan_state_t;

endpackage

// File: rtl/mii_ctrl_calc.sv
module mii_ctrl_calc
    import mii_scan_pkg::*;
(
    input  logic [DATA_W-1:0] cur_val,
    input  logic              force_media,
    input  logic              full_duplex,
    input  logic              media_100,
    output logic [DATA_W-1:0] new_val,
    output logic              an_flip,
    output logic              changed
);

    logic [DATA_W-1:0] stage;
    logic [DATA_W-1:0] shaped;

    // auto-negotiation enable handling
    always_comb begin
        if (!force_media) begin
            stage   = cur_val | CTRL_AN_EN;
            an_flip = (stage != cur_val);
            if (an_flip) begin
                stage = stage | CTRL_AN_RESTART;
            end
        end else begin
            stage   = cur_val & ~CTRL_AN_EN;
            an_flip = (stage != cur_val);
        end
    end

    // scrub then apply requested duplex / speed
    always_comb begin
        shaped = stage & ~CTRL_SCRUB;
        if (full_duplex) begin
            shaped = shaped | CTRL_FDX;
        end
        if (force_media && media_100) begin
            shaped = shaped | CTRL_SPD100;
        end
    end

    assign new_val = shaped;
    assign changed = (shaped != cur_val);

endmodule

// File: rtl/mii_adv_select.sv
module mii_adv_select
    import mii_scan_pkg::*;
(
    input  logic [DATA_W-1:0] global_adv,
    input  logic [DATA_W-1:0] slot_adv,
    input  logic [DATA_W-1:0] phy_adv,
    output logic [DATA_W-1:0] adv_use,
    output logic              global_wins,
    output logic              adopt_phy
);

    logic slot_set;

    assign global_wins = (global_adv != '0);
    assign slot_set    = (slot_adv != '0);
    assign adopt_phy   = !global_wins && !slot_set;

    always_comb begin
        if (global_wins) begin
            adv_use = global_adv;
        end else if (slot_set) begin
            adv_use = slot_adv;
        end else begin
            adv_use = phy_adv;
        end
    end

endmodule

// File: rtl/mii_settle_timer.sv
module mii_settle_timer #(
    parameter int CYCLES = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);

    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= CW'(CYCLES - 1);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign expired = (remain == '0);

endmodule

// File: rtl/mii_scan_seq.sv
module mii_scan_seq
    import mii_scan_pkg::*;
#(
    parameter int SLOTS         = 2,
    parameter int SETTLE_CYCLES = 1250
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic                         mii_expected,
    input  logic                         force_media,
    input  logic                         media_100,
    input  logic                         full_duplex,
    input  logic [15:0]                  cfg_adv,
    output logic                         mdio_req,
    output logic                         mdio_wr,
    output logic [4:0]                   mdio_phy,
    output logic [4:0]                   mdio_reg,
    output logic [15:0]                  mdio_wdata,
    input  logic                         mdio_ack,
    input  logic [15:0]                  mdio_rdata,
    output logic [SLOTS*5-1:0]           phy_table,
    output logic [$clog2(SLOTS+1)-1:0]   phy_count,
    output logic                         done
);

    localparam int CNT_W = $clog2(SLOTS + 1);
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam logic [5:0] LAST_PROBE = 6'd32;

    scan_state_t state, state_nx, ctrl_route;

    logic [5:0]        probe_n;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] adv_q;
    logic [DATA_W-1:0] adv_use_q;
    logic [DATA_W-1:0] global_q;
    logic [DATA_W-1:0] slot_adv_q [SLOTS];
    logic [ADDR_W-1:0] tab_q      [SLOTS];
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx;

    logic              stat_hit;
    logic [DATA_W-1:0] cap_adv;
    logic              adv_empty;
    logic              scan_end;
    logic              launch;

    logic [DATA_W-1:0] ctrl_new;
    logic              an_flip;
    logic              ctrl_diff;
    logic [DATA_W-1:0] adv_pick;
    logic              global_wins;
    logic              adopt_phy;
    logic              settle_load;
    logic              settle_done;

    assign idx       = cnt_q[IDX_W-1:0];
    assign stat_hit  = ((mdio_rdata & STAT_PAT_MASK) == STAT_PAT_VAL) ||
                       (!mdio_rdata[9] && ((mdio_rdata & STAT_ABIL) != '0));
    assign cap_adv   = ((mdio_rdata >> 6) & CAP_MASK) | 16'h0001;
    assign adv_empty = ((mdio_rdata & ADV_ABIL) == '0);
    assign scan_end  = (probe_n == LAST_PROBE) || (cnt_q == CNT_W'(SLOTS));
    assign launch    = start && ((state == S_IDLE) || (state == S_DONE));

    mii_ctrl_calc u_ctrl (
        .cur_val     (ctrl_q),
        .force_media (force_media),
        .full_duplex (full_duplex),
        .media_100   (media_100),
        .new_val     (ctrl_new),
        .an_flip     (an_flip),
        .changed     (ctrl_diff)
    );

    mii_adv_select u_adv (
        .global_adv  (global_q),
        .slot_adv    (slot_adv_q[idx]),
        .phy_adv     (adv_q),
        .adv_use     (adv_pick),
        .global_wins (global_wins),
        .adopt_phy   (adopt_phy)
    );

    assign settle_load = (state == S_WR_CTRL1) && mdio_ack;

    mii_settle_timer #(
        .CYCLES (SETTLE_CYCLES)
    ) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (settle_load),
        .expired (settle_done)
    );

    // where a kept PHY goes once its advertisement is settled
    always_comb begin
        if (!ctrl_diff) begin
            ctrl_route = S_NEXT;
        end else if (an_flip) begin
            ctrl_route = S_WR_CTRL1;
        end else begin
            ctrl_route = S_WR_CTRL2;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:     if (start) state_nx = S_PROBE;
            S_PROBE:    if (mdio_ack) state_nx = stat_hit ? S_RD_CTRL : S_NEXT;
            S_RD_CTRL:  if (mdio_ack) state_nx = S_RD_ADV;
            S_RD_ADV:   if (mdio_ack) state_nx = adv_empty ? S_RD_CAP : S_PICK;
            S_RD_CAP:   if (mdio_ack) state_nx = S_PICK;
            S_PICK:     state_nx = (adv_pick != adv_q) ? S_WR_ADV : ctrl_route;
            S_WR_ADV:   if (mdio_ack) state_nx = ctrl_route;
            S_WR_CTRL1: if (mdio_ack) state_nx = S_SETTLE;
            S_SETTLE:   if (settle_done) state_nx = S_WR_CTRL2;
            S_WR_CTRL2: if (mdio_ack) state_nx = S_NEXT;
            S_NEXT:     state_nx = scan_end ? S_FILL : S_PROBE;
            S_FILL:     state_nx = S_DONE;
            S_DONE:     if (start) state_nx = S_PROBE;
            default:    state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // scan datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            probe_n   <= 6'd1;
            ctrl_q    <= '0;
            adv_q     <= '0;
            adv_use_q <= '0;
            global_q  <= '0;
            cnt_q     <= '0;
            for (int k = 0; k < SLOTS; k++) begin
                slot_adv_q[k] <= '0;
                tab_q[k]      <= '0;
            end
        end else begin
            if (launch) begin
                probe_n  <= 6'd1;
                cnt_q    <= '0;
                global_q <= cfg_adv;
                for (int k = 0; k < SLOTS; k++) begin
                    tab_q[k] <= '0;
                end
            end
            if ((state == S_RD_CTRL) && mdio_ack) begin
                ctrl_q <= mdio_rdata;
            end
            if ((state == S_RD_ADV) && mdio_ack) begin
                adv_q <= mdio_rdata;
            end
            if ((state == S_RD_CAP) && mdio_ack) begin
                adv_q <= cap_adv;
            end
            if (state == S_PICK) begin
                adv_use_q  <= adv_pick;
                tab_q[idx] <= probe_n[ADDR_W-1:0];
                cnt_q      <= cnt_q + 1'b1;
                if (global_wins) begin
                    slot_adv_q[idx] <= global_q;
                end
                if (adopt_phy) begin
                    slot_adv_q[idx] <= adv_q;
                    global_q        <= adv_q;
                end
            end
            if ((state == S_NEXT) && !scan_end) begin
                probe_n <= probe_n + 1'b1;
            end
            if ((state == S_FILL) && mii_expected && (cnt_q == '0)) begin
                tab_q[0] <= 5'd1;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        mdio_req   = 1'b0;
        mdio_wr    = 1'b0;
        mdio_reg   = REG_STAT;
        mdio_wdata = '0;
        done       = 1'b0;
        unique case (state)
            S_PROBE, S_RD_CAP: begin
                mdio_req = 1'b1;
                mdio_reg = REG_STAT;
            end
            S_RD_CTRL: begin
                mdio_req = 1'b1;
                mdio_reg = REG_CTRL;
            end
            S_RD_ADV: begin
                mdio_req = 1'b1;
                mdio_reg = REG_ADV;
            end
            S_WR_ADV: begin
                mdio_req   = 1'b1;
                mdio_wr    = 1'b1;
                mdio_reg   = REG_ADV;
                mdio_wdata = adv_use_q;
            end
            S_WR_CTRL1, S_WR_CTRL2: begin
                mdio_req   = 1'b1;
                mdio_wr    = 1'b1;
                mdio_reg   = REG_CTRL;
                mdio_wdata = ctrl_new;
            end
            S_DONE: begin
                done = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign mdio_phy  = probe_n[ADDR_W-1:0];
    assign phy_count = cnt_q;

    for (genvar g = 0; g < SLOTS; g++) begin : g_table
        assign phy_table[g*5 +: 5] = tab_q[g];
    end

endmodule

// File: rtl/mii_scan_chk.sv
module mii_scan_chk #(
    parameter int SLOTS         = 2,
    parameter int SETTLE_CYCLES = 1250
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       mdio_req,
    input logic                       mdio_wr,
    input logic [4:0]                 mdio_phy,
    input logic [4:0]                 mdio_reg,
    input logic [15:0]                mdio_wdata,
    input logic                       mdio_ack,
    input logic [$clog2(SLOTS+1)-1:0] phy_count,
    input logic                       done
);

    logic [31:0] since_ack;
    logic        last_ctrl_wr;
    logic [4:0]  last_phy;
    logic        prev_req;
    logic        prev_ack;
    logic        txn_start;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_ack    <= '0;
            last_ctrl_wr <= 1'b0;
            last_phy     <= '0;
            prev_req     <= 1'b0;
            prev_ack     <= 1'b0;
        end else begin
            prev_req <= mdio_req;
            prev_ack <= mdio_ack;
            if (mdio_req && mdio_ack) begin
                since_ack    <= '0;
                last_ctrl_wr <= mdio_wr && (mdio_reg == 5'd0);
                last_phy     <= mdio_phy;
            end else if (since_ack != '1) begin
                since_ack <= since_ack + 1'b1;
            end
        end
    end

    assign txn_start = mdio_req && (!prev_req || prev_ack);

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_req && !mdio_ack) |=> (mdio_req && $stable(mdio_wr) && $stable(mdio_phy)
                                     && $stable(mdio_reg) && $stable(mdio_wdata)));

    assert_ctrl_scrub_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_req && mdio_wr && (mdio_reg == 5'd0)) |-> ((mdio_wdata & 16'hCC80) == 16'h0000));

    assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(phy_count) <= SLOTS));

    assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mdio_req);

    assert_settle_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_start && mdio_wr && (mdio_reg == 5'd0) && last_ctrl_wr && (mdio_phy == last_phy))
        |-> (since_ack >= 32'(SETTLE_CYCLES)));

endmodule

bind mii_scan_seq mii_scan_chk #(
    .SLOTS         (SLOTS),
    .SETTLE_CYCLES (SETTLE_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mdio_req   (mdio_req),
    .mdio_wr    (mdio_wr),
    .mdio_phy   (mdio_phy),
    .mdio_reg   (mdio_reg),
    .mdio_wdata (mdio_wdata),
    .mdio_ack   (mdio_ack),
    .phy_count  (phy_count),
    .done       (done)
);

// File: tb/tb_mii_scan_seq.sv
module tb_mii_scan_seq;

    localparam int SLOTS  = 2;
    localparam int SETTLE = 20;
    localparam int LAT    = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic mii_expected = 1'b0;
    logic force_media = 1'b0;
    logic media_100 = 1'b0;
    logic full_duplex = 1'b0;
    logic [15:0] cfg_adv = '0;
    logic mdio_req, mdio_wr;
    logic [4:0] mdio_phy, mdio_reg;
    logic [15:0] mdio_wdata;
    logic mdio_ack = 1'b0;
    logic [15:0] mdio_rdata = '0;
    logic [SLOTS*5-1:0] phy_table;
    logic [$clog2(SLOTS+1)-1:0] phy_count;
    logic done;

    always #4 clk = ~clk;

    mii_scan_seq #(.SLOTS(SLOTS), .SETTLE_CYCLES(SETTLE)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mii_expected(mii_expected),
        .force_media(force_media), .media_100(media_100), .full_duplex(full_duplex),
        .cfg_adv(cfg_adv), .mdio_req(mdio_req), .mdio_wr(mdio_wr), .mdio_phy(mdio_phy),
        .mdio_reg(mdio_reg), .mdio_wdata(mdio_wdata), .mdio_ack(mdio_ack),
        .mdio_rdata(mdio_rdata), .phy_table(phy_table), .phy_count(phy_count), .done(done)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] phy_regs [32][32];
    bit          phy_here [32];
    logic [27:0] exp_q [$];          // {settle, wr, phy, reg, data}
    logic [15:0] m_slot_adv [SLOTS];
    int          m_tab [SLOTS];
    int          m_cnt;
    int          cyc = 0;
    int          last_ack_cyc = 0;
    int          wcnt = 0;

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", what, act, exp);
        end
    endtask

    function automatic logic [15:0] peek(input int a, input int r);
        return phy_here[a] ? phy_regs[a][r] : 16'hFFFF;
    endfunction

    // MDIO master and PHY model, compared against the expected queue each clock
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (!rst_n) begin
                mdio_ack = 1'b0;
                wcnt = 0;
            end else if (mdio_ack) begin
                mdio_ack = 1'b0;
            end else if (mdio_req) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1/R2 unexpected request", {mdio_phy, mdio_reg}, 0);
                end else begin
                    logic [27:0] h;
                    h = exp_q[0];
                    if (wcnt == 0 && h[27]) begin
                        check((cyc - last_ack_cyc) >= SETTLE && (cyc - last_ack_cyc) <= SETTLE + 2,
                              "R8 settle gap", cyc - last_ack_cyc, SETTLE + 1);
                    end
                    check(mdio_wr == h[26] && mdio_phy == h[25:21] && mdio_reg == h[20:16]
                          && (!h[26] || mdio_wdata == h[15:0]),
                          "R1/R3/R5/R6/R7/R11 transaction",
                          {mdio_wr, mdio_phy, mdio_reg, mdio_wdata}, h[26:0]);
                end
                wcnt++;
                if (wcnt == LAT) begin
                    if (mdio_wr) begin
                        if (phy_here[mdio_phy]) phy_regs[mdio_phy][mdio_reg] = mdio_wdata;
                    end else begin
                        mdio_rdata = peek(int'(mdio_phy), int'(mdio_reg));
                    end
                    mdio_ack = 1'b1;
                    last_ack_cyc = cyc;
                    if (exp_q.size() != 0) void'(exp_q.pop_front());
                    wcnt = 0;
                end
            end
        end
    end

    function automatic logic [27:0] txn(input bit settle, input bit wr, input int a, input int r,
                                        input logic [15:0] d);
        return {settle, wr, 5'(a), 5'(r), d};
    endfunction

    task automatic build_model(input bit exp_mii, input bit frc, input bit m100, input bit fdx,
                               input logic [15:0] cfg);
        logic [15:0] glob, s, c, a, use_v, t;
        bit flip;
        int idx;
        idx = 0;
        glob = cfg;
        exp_q.delete();
        for (int k = 0; k < SLOTS; k++) m_tab[k] = 0;
        for (int n = 1; n <= 32 && idx < SLOTS; n++) begin
            int ad;
            ad = n % 32;
            exp_q.push_back(txn(0, 0, ad, 1, 0));
            s = peek(ad, 1);
            if (!(((s & 16'h8301) == 16'h8001) || (!s[9] && (s & 16'h7800) != 0))) continue;
            exp_q.push_back(txn(0, 0, ad, 0, 0));
            exp_q.push_back(txn(0, 0, ad, 4, 0));
            c = peek(ad, 0);
            a = peek(ad, 4);
            if ((a & 16'h01E0) == 0) begin
                exp_q.push_back(txn(0, 0, ad, 1, 0));
                a = ((s >> 6) & 16'h03E0) | 16'h0001;
            end
            if (glob != 0) begin
                use_v = glob;
                m_slot_adv[idx] = glob;
            end else if (m_slot_adv[idx] != 0) begin
                use_v = m_slot_adv[idx];
            end else begin
                use_v = a;
                glob = a;
                m_slot_adv[idx] = a;
            end
            m_tab[idx] = ad;
            idx++;
            if (a != use_v) exp_q.push_back(txn(0, 1, ad, 4, use_v));
            if (!frc) begin
                t = c | 16'h1000;
                flip = (t != c);
                if (flip) t = t | 16'h0200;
            end else begin
                t = c & ~16'h1000;
                flip = (t != c);
            end
            t = t & ~16'hED80;
            if (fdx) t = t | 16'h0100;
            if (frc && m100) t = t | 16'h2000;
            if (t != c) begin
                if (flip) exp_q.push_back(txn(0, 1, ad, 0, t));
                exp_q.push_back(txn(flip, 1, ad, 0, t));
            end
        end
        m_cnt = idx;
        if (exp_mii && idx == 0) m_tab[0] = 1;
    endtask

    task automatic clear_phys();
        for (int a = 0; a < 32; a++) phy_here[a] = 1'b0;
    endtask

    task automatic add_phy(input int a, input logic [15:0] st, input logic [15:0] ct,
                           input logic [15:0] ad);
        phy_here[a] = 1'b1;
        for (int r = 0; r < 32; r++) phy_regs[a][r] = 16'h0000;
        phy_regs[a][1] = st;
        phy_regs[a][0] = ct;
        phy_regs[a][4] = ad;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < SLOTS; k++) m_slot_adv[k] = '0;
        exp_q.delete();
    endtask

    task automatic run_scan(input string name, input bit exp_mii, input bit frc, input bit m100,
                            input bit fdx, input logic [15:0] cfg);
        int guard;
        @(negedge clk);
        mii_expected = exp_mii;
        force_media  = frc;
        media_100    = m100;
        full_duplex  = fdx;
        cfg_adv      = cfg;
        build_model(exp_mii, frc, m100, fdx, cfg);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, {"R10 done cleared by start ", name}, done, 0);
        guard = 0;
        while (!done && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        check(done == 1'b1, {"R10 done raised ", name}, done, 1);
        check(mdio_req == 1'b0, {"R10 idle bus when done ", name}, mdio_req, 0);
        check(exp_q.size() == 0, {"R1/R8 all transactions seen ", name}, exp_q.size(), 0);
        check(int'(phy_count) == m_cnt, {"R10 phy_count ", name}, phy_count, m_cnt);
        for (int k = 0; k < SLOTS; k++) begin
            check(int'(phy_table[k*5 +: 5]) == m_tab[k], {"R9/R10 table slot ", name},
                  phy_table[k*5 +: 5], m_tab[k]);
        end
        repeat (3) @(negedge clk);
        check(done == 1'b1, {"R10 done holds ", name}, done, 1);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R10 watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        clear_phys();
        for (int k = 0; k < SLOTS; k++) m_slot_adv[k] = '0;
        do_reset();
        @(negedge clk);
        check(done == 1'b0, "R10 reset done", done, 0);
        check(phy_count == '0, "R10 reset count", phy_count, 0);
        check(phy_table == '0, "R10 reset table", phy_table, 0);
        check(mdio_req == 1'b0, "R10 reset req", mdio_req, 0);

        // R9: no PHY, fallback on and off
        run_scan("empty expected", 1, 0, 0, 0, 16'h0000);
        check(phy_table[4:0] == 5'd1 && phy_count == '0, "R9 fallback address 1",
              phy_table[4:0], 1);
        run_scan("empty unexpected", 0, 0, 0, 0, 16'h0000);

        // R2: two rejected status patterns around an accepted one, auto single write
        add_phy(5, 16'h7809, 16'h3100, 16'h01E1);
        add_phy(9, 16'h7A00, 16'h0000, 16'h01E1);
        add_phy(12, 16'h0000, 16'h0000, 16'h01E1);
        run_scan("auto single", 0, 0, 0, 0, 16'h0000);
        check(phy_count == 1 && phy_table[4:0] == 5'd5, "R2 only address 5 kept",
              phy_table[4:0], 5);

        // R1/R3/R6/R7/R8: address 31 before 0, derived advertisement, forced double write
        clear_phys();
        add_phy(31, 16'h8005, 16'h1000, 16'h0000);
        add_phy(0, 16'h7809, 16'h0000, 16'h01E1);
        run_scan("forced 100 fdx", 0, 1, 1, 1, 16'h05E1);
        check(phy_table[4:0] == 5'd31 && phy_table[9:5] == 5'd0, "R1 order 31 then 0",
              phy_table, 31);
        check(phy_regs[31][0] == 16'h2100, "R7 forced control value", phy_regs[31][0], 16'h2100);
        check(phy_regs[31][4] == 16'h05E1, "R5 advertisement written", phy_regs[31][4], 16'h05E1);

        // R4: derived value becomes global after reset; table full stops the probe
        do_reset();
        clear_phys();
        add_phy(2, 16'h7809, 16'h0000, 16'h0141);
        add_phy(3, 16'h7809, 16'h1000, 16'h01E1);
        add_phy(4, 16'h7809, 16'h0000, 16'h01E1);
        run_scan("fill table", 0, 0, 0, 1, 16'h0000);
        check(phy_regs[3][4] == 16'h0141, "R4 global from first PHY", phy_regs[3][4], 16'h0141);
        check(phy_regs[4][0] == 16'h0000, "R1 address past full table untouched",
              phy_regs[4][0], 0);
        check(phy_regs[2][0] == 16'h1300, "R6 auto enable with restart", phy_regs[2][0], 16'h1300);

        // R4: slot value used when global is zero
        phy_regs[2][4] = 16'h0061;
        run_scan("slot priority", 0, 0, 0, 0, 16'h0000);
        check(phy_regs[2][4] == 16'h0141, "R4 slot value written", phy_regs[2][4], 16'h0141);

        summary();
        $finish;
    end

endmodule